// File: doc/BRIEF.md
# ATM Cell Header Check Byte Generator

This block sits in the transmit path of a byte-wide ATM cell stream. It watches each 53-byte cell go past and works out the header error control byte from the four header bytes that open the cell. When the fifth byte arrives, the block does one of three things with it. It can put the freshly computed check byte in its place. It can leave the byte supplied upstream untouched. It can write a check byte that is wrong on purpose, so that the far end's error handling can be tested.

Bytes move with a valid/ready handshake on both sides. A start-of-cell flag marks the first header byte. The output goes through a single register stage, and a stall on the output ready reaches the input ready combinationally, so the stream never loses or repeats a byte. The 2-bit mode input is captured with the first byte of each cell, which means every cell is handled under a single mode.

Top module: `hec_inserter`

## Requirements
- R1: While reset is high, and on the first cycle after it is released, `out_valid` is 0 and `in_ready` is 1.
- R2: The check byte is a CRC-8 with generator x^8+x^2+x+1. It is computed most significant bit first from an all-zero start over cell bytes 1 to 4, where byte 1 is the one carrying `in_soc`. The remainder is then XORed with 0x55. For example, the header 00 00 00 01 gives 0x52.
- R3: With mode 2'b00, output byte 5 of a cell is the check byte from R2, whatever byte 5 carried on input.
- R4: With mode 2'b01 or 2'b11, output byte 5 equals input byte 5.
- R5: With mode 2'b10, output byte 5 is the R2 check byte with bit 0 inverted.
- R6: Every byte other than byte 5 leaves with its input value, in every mode, and `out_soc` repeats the `in_soc` that came with the byte.
- R7: The mode used for a cell is the value on `mode` in the cycle its start-of-cell byte is accepted. Changes on `mode` later in the cell have no effect on that cell.
- R8: A byte accepted on a clock edge appears on `out_valid`/`out_data` in the next cycle. Bytes leave in the order they were accepted.
- R9: `in_ready` equals `out_ready OR NOT out_valid`. While `out_valid` is 1 and `out_ready` is 0, the output byte and flag hold steady.
- R10: A byte with `in_soc` set starts a new cell even if the previous cell is not finished. Bytes accepted after the 53rd byte without a new `in_soc` pass through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 2 | 00 insert, 01/11 pass through, 10 corrupt |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Block can take the input byte |
| in_data | input | 8 | Input byte |
| in_soc | input | 1 | Input byte is header byte 1 |
| out_valid | output | 1 | Output byte present |
| out_ready | input | 1 | Downstream takes the output byte |
| out_data | output | 8 | Output byte |
| out_soc | output | 1 | Output byte is header byte 1 |

## Verification
Two pairs of events can land in the same cycle. A change on `mode` can coincide with the acceptance of a start-of-cell byte. Separately, the byte-5 substitution can be accepted while the output register is stalled. The bench changes `mode` at random on every cycle and throttles `out_ready` at random, so both collisions occur many times. An independent reference model captures the mode only on start-of-cell bytes. Every output byte is compared with the model's value, and stalled cycles are checked for a held output.

// File: rtl/hec_pkg.sv
package hec_pkg;

    localparam int          BYTE_W     = 8;
    localparam logic [7:0]  CRC_POLY   = 8'h07;
    localparam logic [7:0]  HEC_COSET  = 8'h55;
    localparam logic [7:0]  CORRUPT_MASK = 8'h01;

    typedef enum logic [1:0] {
        HM_INSERT  = 2'b00,
        HM_PASS    = 2'b01,
        HM_CORRUPT = 2'b10,
        HM_PASS_B  = 2'b11
    } hec_mode_e;

    typedef struct packed {
        logic              soc;
        logic [BYTE_W-1:0] data;
    } beat_t;

    function automatic logic [7:0] crc8_step(input logic [7:0] crc_in,
                                             input logic [7:0] din);
        logic [7:0] c;
        logic       fb;
        c = crc_in;
        for (int i = 7; i >= 0; i--) begin
            fb = c[7] ^ din[i];
            c  = {c[6:0], 1'b0};
            if (fb) c = c ^ CRC_POLY;
        end
        return c;
    endfunction

endpackage

// File: rtl/hec_cell_tracker.sv
module hec_cell_tracker
    import hec_pkg::*;
#(
    parameter int CELL_BYTES = 53,
    parameter int HDR_BYTES  = 4,
    localparam int POS_W     = $clog2(CELL_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             take,
    input  logic             soc,
    input  hec_mode_e        mode_in,
    output hec_mode_e        cur_mode,
    output logic             first,
    output logic             in_header,
    output logic             at_hec
);
    localparam logic [POS_W-1:0] IDLE_POS = POS_W'(CELL_BYTES);

    logic [POS_W-1:0] pos_q;
    logic [POS_W-1:0] idx;
    hec_mode_e        mode_q;

    assign idx       = soc ? '0 : pos_q;
    assign cur_mode  = soc ? mode_in : mode_q;
    assign first     = (idx == '0);
    assign in_header = (idx < POS_W'(HDR_BYTES));
    assign at_hec    = (idx == POS_W'(HDR_BYTES));

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q  <= IDLE_POS;
            mode_q <= HM_PASS;
        end else if (take) begin
            pos_q <= (idx < IDLE_POS) ? idx + 1'b1 : IDLE_POS;
            if (soc) mode_q <= mode_in;
        end
    end

    // R10: position never runs past the idle marker
    a_r10_pos_bounded: assert property (@(posedge clk) disable iff (rst)
        pos_q <= IDLE_POS);

    // R7: latched mode only moves on an accepted start-of-cell byte
    a_r7_mode_held: assert property (@(posedge clk) disable iff (rst)
        !(take && soc) |=> $stable(mode_q));

endmodule

// File: rtl/hec_crc_acc.sv
module hec_crc_acc
    import hec_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       take,
    input  logic       first,
    input  logic       in_header,
    input  logic [7:0] din,
    output logic [7:0] hec_good
);
    logic [7:0] crc_q;
    logic [7:0] seed;

    assign seed     = first ? 8'h00 : crc_q;
    assign hec_good = crc_q ^ HEC_COSET;

    always_ff @(posedge clk) begin
        if (rst) begin
            crc_q <= '0;
        end else if (take && in_header) begin
            crc_q <= crc8_step(seed, din);
        end
    end

    // R2: remainder only moves when a header byte is taken
    a_r2_crc_quiet: assert property (@(posedge clk) disable iff (rst)
        !(take && in_header) |=> $stable(crc_q));

endmodule

// File: rtl/hec_inserter.sv
module hec_inserter
    import hec_pkg::*;
#(
    parameter int CELL_BYTES = 53,
    parameter int HDR_BYTES  = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic [7:0] in_data,
    input  logic       in_soc,
    output logic       out_valid,
    input  logic       out_ready,
    output logic [7:0] out_data,
    output logic       out_soc
);
    logic      take;
    hec_mode_e cur_mode;
    logic      first, in_header, at_hec;
    logic [7:0] hec_good;
    beat_t     nxt, out_q;
    logic      vld_q;

    assign in_ready = out_ready || !vld_q;
    assign take     = in_valid && in_ready;

    hec_cell_tracker #(
        .CELL_BYTES (CELL_BYTES),
        .HDR_BYTES  (HDR_BYTES)
    ) u_track (
        .clk       (clk),
        .rst       (rst),
        .take      (take),
        .soc       (in_soc),
        .mode_in   (hec_mode_e'(mode)),
        .cur_mode  (cur_mode),
        .first     (first),
        .in_header (in_header),
        .at_hec    (at_hec)
    );

    hec_crc_acc u_crc (
        .clk       (clk),
        .rst       (rst),
        .take      (take),
        .first     (first),
        .in_header (in_header),
        .din       (in_data),
        .hec_good  (hec_good)
    );

    always_comb begin
        nxt.soc  = in_soc;
        nxt.data = in_data;
        if (at_hec) begin
            unique case (cur_mode)
                HM_INSERT:  nxt.data = hec_good;
                HM_CORRUPT: nxt.data = hec_good ^ CORRUPT_MASK;
                default:    nxt.data = in_data;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            out_q <= '0;
        end else if (take) begin
            vld_q <= 1'b1;
            out_q <= nxt;
        end else if (out_ready) begin
            vld_q <= 1'b0;
        end
    end

    assign out_valid = vld_q;
    assign out_data  = out_q.data;
    assign out_soc   = out_q.soc;

    // R8: an accepted byte is presented in the next cycle
    a_r8_one_stage: assert property (@(posedge clk) disable iff (rst)
        take |=> out_valid);

    // R9: stalled output holds its contents
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_soc)));

    // R9: an empty stage always accepts
    a_r9_empty_ready: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> in_ready);

    // R6: start-of-cell flag travels with its byte
    a_r6_soc_follows: assert property (@(posedge clk) disable iff (rst)
        (take && in_soc) |=> out_soc);

endmodule

// File: tb/hec_inserter_bench.sv
module hec_inserter_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode = 2'b00;
    logic       in_valid = 1'b0;
    logic       in_soc = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       out_ready = 1'b0;
    logic       in_ready, out_valid, out_soc;
    logic [7:0] out_data;

    always #2 clk = ~clk;

    hec_inserter u_hec_inserter (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .in_soc    (in_soc),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data),
        .out_soc   (out_soc)
    );

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done  = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // reference model state
    int         m_pos  = 53;
    logic [1:0] m_mode = 2'b01;
    logic [7:0] m_crc  = 8'h00;
    logic [9:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] hec_seen;

    function automatic logic [7:0] ref_crc(input logic [7:0] c0, input logic [7:0] d);
        logic [7:0] c;
        c = c0 ^ d;
        for (int k = 0; k < 8; k++) c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
        return c;
    endfunction

    task automatic model_push(input logic soc, input logic [7:0] d, input logic [1:0] md);
        int         idx;
        logic [1:0] eff;
        logic [7:0] e;
        string      t;
        bit         is5;
        idx = soc ? 0 : m_pos;
        t   = "R6 byte";
        if (soc && m_pos > 0 && m_pos < 53) t = "R10 restart";
        if (idx == 0) begin m_mode = md; m_crc = 8'h00; end
        eff = (idx == 0) ? md : m_mode;
        e   = d;
        is5 = 0;
        if (idx < 4) m_crc = ref_crc(m_crc, d);
        if (idx == 4) begin
            is5 = 1;
            case (eff)
                2'b00:   begin e = m_crc ^ 8'h55;         t = "R3 R2 byte5"; end
                2'b10:   begin e = m_crc ^ 8'h55 ^ 8'h01; t = "R5 R2 byte5"; end
                default: begin e = d;                     t = "R4 byte5";    end
            endcase
            if (md != eff) t = {t, " R7"};
        end
        if (idx >= 53) t = "R10 stray";
        m_pos = (idx < 53) ? idx + 1 : 53;
        exp_q.push_back({is5, soc, e});
        tag_q.push_back(t);
    endtask

    bit         prev_take  = 0;
    bit         prev_stall = 0;
    logic [8:0] prev_out;
    bit         last_take;

    // call right after a falling edge with inputs already driven
    task automatic tick();
        logic [9:0] e;
        string      t;
        #1;
        if (prev_take)  chk(out_valid === 1'b1, "R8 latency", out_valid, 1);
        if (prev_stall) chk(out_valid === 1'b1 && {out_soc, out_data} === prev_out,
                            "R9 hold", {out_soc, out_data}, prev_out);
        chk(in_ready === (out_ready || !out_valid), "R9 ready", in_ready, out_ready || !out_valid);
        if (out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                chk(0, "R8 extra output", out_data, 0);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk({out_soc, out_data} === e[8:0], t, {out_soc, out_data}, e[8:0]);
                if (e[9]) hec_seen = out_data;
            end
        end
        last_take = in_valid && in_ready;
        if (last_take) model_push(in_soc, in_data, mode);
        prev_take  = last_take;
        prev_stall = out_valid && !out_ready;
        prev_out   = {out_soc, out_data};
        @(negedge clk);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R8 watchdog expired actual=0 expected=1");
            summary();
            $finish;
        end
    end

    task automatic directed_cell(input logic [1:0] md, input logic [1:0] late_md);
        for (int b = 0; b < 53; b++) begin
            in_valid = 1'b1;
            in_soc   = (b == 0);
            mode     = (b >= 2) ? late_md : md;
            in_data  = (b == 3) ? 8'h01 : (b < 3) ? 8'h00 : (b == 4) ? 8'hAA : 8'(b);
            tick();
        end
        in_valid = 1'b0;
        in_soc   = 1'b0;
        repeat (3) tick();
    endtask

    initial begin
        bit         have;
        logic [8:0] pend;
        int         g_idx, g_len, g_extra;
        void'($urandom(32'd20240611));
        @(negedge clk);
        repeat (2) begin
            #1;
            chk(out_valid === 1'b0, "R1 reset valid", out_valid, 0);
            chk(in_ready === 1'b1, "R1 reset ready", in_ready, 1);
            @(negedge clk);
        end
        rst = 1'b0;
        #1;
        chk(out_valid === 1'b0 && in_ready === 1'b1, "R1 after release", {out_valid, in_ready}, 2'b01);
        @(negedge clk);

        out_ready = 1'b1;
        chk(ref_crc(ref_crc(ref_crc(ref_crc(8'h00, 8'h00), 8'h00), 8'h00), 8'h01) ^ 8'h55 == 8'h52,
            "R2 model vector", 0, 8'h52);
        directed_cell(2'b00, 2'b10);
        chk(hec_seen == 8'h52, "R3 R7 inserted byte5", hec_seen, 8'h52);
        directed_cell(2'b01, 2'b00);
        chk(hec_seen == 8'hAA, "R4 R7 passed byte5", hec_seen, 8'hAA);
        directed_cell(2'b10, 2'b01);
        chk(hec_seen == 8'h53, "R5 corrupted byte5", hec_seen, 8'h53);
        directed_cell(2'b11, 2'b00);
        chk(hec_seen == 8'hAA, "R4 alternate pass byte5", hec_seen, 8'hAA);

        have = 0; g_idx = 0; g_len = 53; g_extra = 0; pend = '0;
        for (int cyc = 0; cyc < 6000; cyc++) begin
            if (!have) begin
                if (g_idx < g_len) begin
                    pend = {g_idx == 0, 8'($urandom)};
                    if (g_idx < 4 && $urandom % 4 == 0) pend[7:0] = 8'h00;
                    g_idx++;
                end else if (g_extra > 0) begin
                    pend = {1'b0, 8'($urandom)};
                    g_extra--;
                end else begin
                    g_len   = ($urandom % 10 == 0) ? 5 + int'($urandom % 48) : 53;
                    g_extra = ($urandom % 8 == 0) ? 1 + int'($urandom % 3) : 0;
                    pend    = {1'b1, 8'($urandom)};
                    g_idx   = 1;
                end
                have = 1;
            end
            in_valid  = ($urandom % 10) < 7;
            in_soc    = pend[8];
            in_data   = pend[7:0];
            mode      = 2'($urandom);
            out_ready = ($urandom % 10) < 7;
            tick();
            if (last_take) have = 0;
        end

        in_valid  = 1'b0;
        out_ready = 1'b1;
        repeat (5) tick();
        chk(exp_q.size() == 0, "R8 drained", exp_q.size(), 0);

        done = 1;
        summary();
        $finish;
    end

endmodule